// File: doc/BRIEF.md
# AXI Response and Read-Data Ready Pacer

This block produces the BREADY and RREADY outputs of an AXI master and deliberately slows the handshakes on those two channels. Each channel is paced by its own delay value, given in whole ACLK cycles. A single mode bit picks the event from which delays are counted. In valid-referenced mode the count starts when the slave raises VALID, and READY is granted once the count reaches the delay. In phase-referenced mode the count starts at the end of the previous handshake on that channel, or at reset release, so READY may already be high before VALID arrives.

The block only paces handshakes. It does not generate addresses or write data, track bursts, check responses or store data. The mode and delay inputs are static configuration. They are changed only while reset is held. The block is placed between a master's response and read-data sinks and the slave. It is used to stress slaves with back-pressure that can be repeated exactly.

Top module: `hs_ready_pacer`

## Requirements
- R1: BREADY is paced by `cfg_wresp_delay` and RREADY by `cfg_rdata_delay`. A channel's internal count never exceeds its own delay value.
- R2: With `cfg_ref_mode` = 0 (valid-referenced), READY stays low while VALID is low. When VALID is first seen high in cycle 0 and held, READY rises in cycle d, where d is the channel delay.
- R3: With `cfg_ref_mode` = 0 and delay 0, READY equals VALID in the same cycle, with no register on the path.
- R4: A handshake completes on a rising ACLK edge where VALID and READY are both high. For a delay above 0, READY is low in the cycle after that edge and a fresh count begins. Every beat of a read burst is therefore delayed again by the full amount.
- R5: With `cfg_ref_mode` = 1 (phase-referenced), the first cycle after a handshake edge, or the first cycle after reset release, is count 0. READY rises in cycle d whether or not VALID is present. A handshake then completes in the first cycle VALID is high.
- R6: With `cfg_ref_mode` = 1 and delay 0, READY stays high continuously, so beats complete back-to-back.
- R7: While `aresetn` is low, both READY outputs are low whatever the other inputs are, and both counts are cleared.
- R8: The two channels are independent. A stalled or slow response channel does not change the timing of read-data beats, and the reverse also holds.
- R9: In phase-referenced mode, once READY is high it stays high until a handshake takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock; all state changes on its rising edge |
| aresetn | input | 1 | Active-low reset |
| cfg_ref_mode | input | 1 | 0 counts from VALID, 1 counts from the previous handshake |
| cfg_wresp_delay | input | DLY_W | BREADY delay in cycles |
| cfg_rdata_delay | input | DLY_W | RREADY delay in cycles, applied per beat |
| bvalid | input | 1 | Write-response VALID from the slave |
| bready | output | 1 | Paced write-response READY |
| rvalid | input | 1 | Read-data VALID from the slave |
| rready | output | 1 | Paced read-data READY |

## Verification
The assertions watch four things on every cycle. READY stays quiet while VALID is low in valid-referenced mode. READY drops after each handshake when a delay is set. READY equals VALID, or stays high, at zero delay. Phase-referenced READY holds until the handshake. The exact number of wait cycles, the count origin at reset release, the repetition per burst beat and the isolation of one channel from a stall on the other can only be shown by the bench's directed scenarios. Those scenarios measure wait lengths at the ports.

// File: rtl/hs_pacer_pkg.sv
package hs_pacer_pkg;

  typedef enum logic {
    REF_VALID = 1'b0,
    REF_PHASE = 1'b1
  } pace_ref_e;

  localparam int CH_WRESP = 0;
  localparam int CH_RDATA = 1;
  localparam int NUM_CH   = 2;

endpackage

// File: rtl/hs_pacer_count.sv
module hs_pacer_count #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             hold_zero,
  input  logic [DLY_W-1:0] limit,
  output logic [DLY_W-1:0] count,
  output logic             reached
);

  logic [DLY_W-1:0] count_q;
  logic [DLY_W-1:0] count_d;

  function automatic logic [DLY_W-1:0] advance(
    input logic [DLY_W-1:0] cur,
    input logic [DLY_W-1:0] lim,
    input logic             clr,
    input logic             zero
  );
    if (clr || zero)  return '0;
    else if (cur < lim) return cur + 1'b1;
    else              return cur;
  endfunction

  function automatic logic at_or_past(
    input logic [DLY_W-1:0] cur,
    input logic [DLY_W-1:0] lim
  );
    return cur >= lim;
  endfunction

  always_comb count_d = advance(count_q, limit, restart, hold_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count   = count_q;
  assign reached = at_or_past(count_q, limit);

  // limit is static configuration, so the saturating count stays within it
  assert_count_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= limit);

  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count_q == '0));

endmodule

// File: rtl/hs_pacer_lane.sv
module hs_pacer_lane
  import hs_pacer_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pace_ref_e        ref_sel,
  input  logic [DLY_W-1:0] dly,
  input  logic             valid,
  output logic             ready
);

  logic             hs_fire;
  logic             idle_hold;
  logic             gate_open;
  logic [DLY_W-1:0] lane_count;

  // valid-referenced counts only run while VALID is held
  assign idle_hold = (ref_sel == REF_VALID) && !valid;

  hs_pacer_count #(.DLY_W(DLY_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (hs_fire),
    .hold_zero(idle_hold),
    .limit    (dly),
    .count    (lane_count),
    .reached  (gate_open)
  );

  always_comb ready = rst_n && gate_open && ((ref_sel == REF_PHASE) || valid);

  assign hs_fire = valid && ready;

  always_comb begin
    if (!rst_n) assert_reset_quiet_R7: assert (!ready);
  end

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel == REF_VALID && !valid) |-> !ready);

  assert_zero_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel == REF_VALID && dly == '0) |-> (ready == valid));

  assert_drop_after_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fire && dly != '0) |=> !ready);

  assert_zero_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel == REF_PHASE && dly == '0) |-> ready);

  assert_hold_until_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel == REF_PHASE && ready && !hs_fire) |=> ready);

  // count origin check: fresh count after handshake means ready waits dly cycles
  assert_count_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fire && dly != '0) |=> (lane_count == '0));

endmodule

// File: rtl/hs_ready_pacer.sv
module hs_ready_pacer
  import hs_pacer_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             aclk,
  input  logic             aresetn,
  input  logic             cfg_ref_mode,
  input  logic [DLY_W-1:0] cfg_wresp_delay,
  input  logic [DLY_W-1:0] cfg_rdata_delay,
  input  logic             bvalid,
  output logic             bready,
  input  logic             rvalid,
  output logic             rready
);

  pace_ref_e         ref_sel;
  logic [NUM_CH-1:0] valid_vec;
  logic [NUM_CH-1:0] ready_vec;
  logic [DLY_W-1:0]  dly_arr [NUM_CH];

  assign ref_sel = pace_ref_e'(cfg_ref_mode);

  assign valid_vec[CH_WRESP] = bvalid;
  assign valid_vec[CH_RDATA] = rvalid;
  assign dly_arr[CH_WRESP]   = cfg_wresp_delay;
  assign dly_arr[CH_RDATA]   = cfg_rdata_delay;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    hs_pacer_lane #(.DLY_W(DLY_W)) u_lane (
      .clk    (aclk),
      .rst_n  (aresetn),
      .ref_sel(ref_sel),
      .dly    (dly_arr[g]),
      .valid  (valid_vec[g]),
      .ready  (ready_vec[g])
    );
  end

  assign bready = ready_vec[CH_WRESP];
  assign rready = ready_vec[CH_RDATA];

endmodule

// File: tb/hs_ready_pacer_bench.sv
module hs_ready_pacer_bench;

  localparam int CLK_P = 10;
  localparam int DW    = 8;

  logic          aclk    = 1'b0;
  logic          aresetn = 1'b0;
  logic          mode    = 1'b0;
  logic [DW-1:0] bd      = 8'd2;
  logic [DW-1:0] rd      = 8'd2;
  logic          bvalid  = 1'b0;
  logic          rvalid  = 1'b0;
  wire           bready;
  wire           rready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int n;

  hs_ready_pacer #(.DLY_W(DW)) u_hs_ready_pacer (
    .aclk           (aclk),
    .aresetn        (aresetn),
    .cfg_ref_mode   (mode),
    .cfg_wresp_delay(bd),
    .cfg_rdata_delay(rd),
    .bvalid         (bvalid),
    .bready         (bready),
    .rvalid         (rvalid),
    .rready         (rready)
  );

  always #(CLK_P/2) aclk = ~aclk;

  task automatic step();
    @(posedge aclk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic rdy(input int ch);
    return (ch == 0) ? bready : rready;
  endfunction

  task automatic do_reset(input logic m, input int b, input int r);
    aresetn = 1'b0;
    mode    = m;
    bd      = DW'(b);
    rd      = DW'(r);
    bvalid  = 1'b0;
    rvalid  = 1'b0;
    step();
    step();
    aresetn = 1'b1;
  endtask

  task automatic wait_ready(input int ch, input int limit, output int cnt);
    cnt = 0;
    #1;
    while (!rdy(ch) && cnt < limit) begin
      step();
      cnt++;
      #1;
    end
  endtask

  task automatic t_reset();
    aresetn = 1'b0;
    mode = 1'b1; bd = '0; rd = '0;
    bvalid = 1'b1; rvalid = 1'b1;
    step();
    #1;
    check("R7 bready in reset", int'(bready), 0);
    check("R7 rready in reset", int'(rready), 0);
    aresetn = 1'b1;
    #1;
    check("R6 bready after release, zero delay", int'(bready), 1);
    bvalid = 1'b0; rvalid = 1'b0;
  endtask

  task automatic t_valid_ref();
    do_reset(1'b0, 2, 3);
    for (int i = 0; i < 3; i++) begin
      step();
      #1;
      check("R2 bready low while idle", int'(bready), 0);
      check("R2 rready low while idle", int'(rready), 0);
    end
    step();
    bvalid = 1'b1;
    wait_ready(0, 20, n);
    check("R2 R1 bready wait cycles", n, 2);
    step();
    bvalid = 1'b0;
    #1;
    check("R4 bready low after handshake", int'(bready), 0);
    step();
    rvalid = 1'b1;
    wait_ready(1, 20, n);
    check("R1 rready wait cycles", n, 3);
    step();
    rvalid = 1'b0;
  endtask

  task automatic t_zero_valid();
    logic pat [6] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    do_reset(1'b0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      bvalid = pat[i];
      #1;
      check("R3 bready follows bvalid", int'(bready), int'(pat[i]));
      step();
    end
    bvalid = 1'b0;
  endtask

  task automatic t_burst();
    do_reset(1'b0, 2, 2);
    rvalid = 1'b1;
    for (int b = 0; b < 4; b++) begin
      wait_ready(1, 20, n);
      check("R4 per-beat rready wait", n, 2);
      step();
    end
    rvalid = 1'b0;
  endtask

  task automatic t_phase_ref();
    do_reset(1'b1, 3, 1);
    wait_ready(0, 20, n);
    check("R5 bready from reset release", n, 3);
    for (int i = 0; i < 3; i++) begin
      step();
      #1;
      check("R9 bready held without bvalid", int'(bready), 1);
    end
    check("R8 rready open in parallel", int'(rready), 1);
    bvalid = 1'b1;
    #1;
    check("R5 bready high when bvalid arrives", int'(bready), 1);
    step();
    bvalid = 1'b0;
    #1;
    check("R4 bready low after handshake", int'(bready), 0);
    wait_ready(0, 20, n);
    check("R5 bready from previous handshake", n, 3);
  endtask

  task automatic t_phase_zero();
    do_reset(1'b1, 0, 0);
    rvalid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R6 rready back-to-back", int'(rready), 1);
      step();
    end
    rvalid = 1'b0;
  endtask

  task automatic t_independence();
    do_reset(1'b0, 9, 1);
    bvalid = 1'b1;
    rvalid = 1'b1;
    for (int b = 0; b < 3; b++) begin
      wait_ready(1, 20, n);
      check("R8 rready beat during bvalid stall", n, 1);
      step();
    end
    rvalid = 1'b0;
    #1;
    check("R8 bready still stalled", int'(bready), 0);
    wait_ready(0, 20, n);
    check("R8 bready remaining wait", n, 3);
    step();
    bvalid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_valid_ref();
    t_zero_valid();
    t_burst();
    t_phase_ref();
    t_phase_zero();
    t_independence();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule